// File: doc/BRIEF.md
# Two-Stage Serial Clock Divider

This block derives the serial clock of a synchronous serial master from the system clock. Two counters are cascaded. The first, a prescaler, divides by an even value. The second, a post stage, counts prescaler ticks and toggles the serial clock once for every (post + 1) of them. The whole-period division ratio is therefore (1 + post) × pre. The smallest ratio is 2 and the largest is 256 × 254. Odd ratios cannot be produced.

The shift logic uses the level `sclk_o` and two single-cycle strobes. `half_tick_o` marks every serial clock edge. `full_tick_o` marks the falling edge that closes a whole period. Illegal prescaler settings are clamped instead of rejected. While the enable is low, both counters are held at zero and the clock is parked low. A new enable therefore always starts with a complete half period, with no runt pulse.

Top module: `spidiv_top`

## Requirements
- R1: While `rst_i` is high, and in the cycle after it is released, `sclk_o`, `half_tick_o` and `full_tick_o` are 0.
- R2: While `en_i` is low, `sclk_o` stays 0 and neither strobe pulses, for any divider setting.
- R3: With enable held high and settings stable, `sclk_o` changes level every H = (post + 1) × P / 2 system clocks. P is the effective prescaler value. `half_tick_o` is 1 in exactly the cycles in which `sclk_o` holds a level it did not hold in the previous cycle.
- R4: The high phase and the low phase of `sclk_o` each last H clocks, so the duty cycle is 50% and one period lasts (post + 1) × P clocks.
- R5: A prescaler value of 0 or 1 acts as P = 2.
- R6: Bit 0 of the prescaler value is ignored, so an odd value v acts as P = v − 1 (for example, 7 acts as 6).
- R7: After `en_i` is first sampled high at a clock edge, `sclk_o` rises at the H-th such edge, counting that edge as the first.
- R8: `full_tick_o` is 1 exactly in the cycles in which `sclk_o` has just fallen while enabled. It is never 1 without `half_tick_o`.
- R9: When `en_i` is sampled low, `sclk_o` returns to 0 at that edge. A later enable again waits a full H clocks before the first rising edge.
- R10: The extreme setting, prescaler 254 with post 255, gives H = 32512 and a whole period of 65024 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable; low parks the clock and clears both counters |
| pre_div_i | input | 8 | Prescaler value (even, 2..254; clamped) |
| post_div_i | input | 8 | Post-stage value, 0..255 |
| sclk_o | output | 1 | Serial clock level, idles low |
| half_tick_o | output | 1 | One-cycle strobe on every serial clock edge |
| full_tick_o | output | 1 | One-cycle strobe on the falling edge closing a period |

## Verification
The period-window assertion assumes that `pre_div_i` and `post_div_i` do not change while `en_i` is high, because the expected half period is recomputed from the live inputs. The stimulus therefore changes the settings only while the enable is low, and it drops and raises the enable only between the cases it runs. Every other property depends only on the enable and on the output history since reset, so no other assumption about the inputs is needed.

// File: rtl/spidiv_pkg.sv
package spidiv_pkg;

    localparam int PRE_W   = 8;
    localparam int POST_W  = 8;
    localparam int HALF_W  = PRE_W - 1;
    localparam int SPAN_W  = POST_W + HALF_W + 2;

    typedef struct packed {
        logic [HALF_W-1:0] half_pre;
        logic [POST_W-1:0] post_lim;
    } div_cfg_t;

    typedef struct packed {
        logic level;
        logic edge_stb;
        logic close_stb;
    } clk_out_t;

    // Prescaler half count: bit 0 dropped, anything below 2 becomes 2.
    function automatic logic [HALF_W-1:0] clamp_half_pre(input logic [PRE_W-1:0] pre);
        if (pre[PRE_W-1:1] == '0)
            return HALF_W'(1);
        return pre[PRE_W-1:1];
    endfunction

    // Clocks per half period of the serial clock for a given setting.
    function automatic logic [SPAN_W-1:0] half_span(input logic [PRE_W-1:0] pre,
                                                     input logic [POST_W-1:0] post);
        logic [SPAN_W-1:0] a;
        logic [SPAN_W-1:0] b;
        a = SPAN_W'(post) + SPAN_W'(1);
        b = SPAN_W'(clamp_half_pre(pre));
        return a * b;
    endfunction

endpackage

// File: rtl/spidiv_cfg_clamp.sv
module spidiv_cfg_clamp
    import spidiv_pkg::*;
#(
    parameter int PW = PRE_W,
    parameter int QW = POST_W
) (
    input  logic [PW-1:0] pre_i,
    input  logic [QW-1:0] post_i,
    output div_cfg_t      cfg_o
);
    always_comb begin
        cfg_o          = '0;
        cfg_o.half_pre = clamp_half_pre(PRE_W'(pre_i));
        cfg_o.post_lim = POST_W'(post_i);
    end
endmodule

// File: rtl/spidiv_stage.sv
// One counter stage: counts qualifying steps and wraps at the limit.
module spidiv_stage #(
    parameter int CW = 8
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          run_i,
    input  logic          step_i,
    input  logic [CW-1:0] last_i,
    output logic          wrap_o
);
    logic [CW-1:0] cnt_q;

    // >= so that a counter past a lowered limit still wraps at once
    assign wrap_o = run_i && step_i && (cnt_q >= last_i);

    always_ff @(posedge clk_i) begin
        if (rst_i || !run_i)
            cnt_q <= '0;
        else if (wrap_o)
            cnt_q <= '0;
        else if (step_i)
            cnt_q <= cnt_q + CW'(1);
    end
endmodule

// File: rtl/spidiv_sclk_gen.sv
module spidiv_sclk_gen
    import spidiv_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     run_i,
    input  logic     flip_i,
    output clk_out_t out_o
);
    clk_out_t out_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || !run_i) begin
            out_q <= '0;
        end else begin
            out_q.edge_stb  <= flip_i;
            out_q.close_stb <= flip_i && out_q.level;
            if (flip_i)
                out_q.level <= !out_q.level;
        end
    end

    assign out_o = out_q;
endmodule

// File: rtl/spidiv_top.sv
module spidiv_top
    import spidiv_pkg::*;
#(
    parameter int PW = PRE_W,
    parameter int QW = POST_W
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          en_i,
    input  logic [PW-1:0] pre_div_i,
    input  logic [QW-1:0] post_div_i,
    output logic          sclk_o,
    output logic          half_tick_o,
    output logic          full_tick_o
);
    localparam int HW = PW - 1;

    div_cfg_t  cfg;
    logic      pre_wrap;
    logic      post_wrap;
    clk_out_t  clk_out;

    spidiv_cfg_clamp #(.PW(PW), .QW(QW)) u_clamp (
        .pre_i  (pre_div_i),
        .post_i (post_div_i),
        .cfg_o  (cfg)
    );

    // Prescaler: wraps every half_pre clocks, i.e. pre/2.
    spidiv_stage #(.CW(HW)) u_pre (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .run_i  (en_i),
        .step_i (1'b1),
        .last_i (HW'(cfg.half_pre) - HW'(1)),
        .wrap_o (pre_wrap)
    );

    // Post stage: wraps after post+1 prescaler ticks.
    spidiv_stage #(.CW(QW)) u_post (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .run_i  (en_i),
        .step_i (pre_wrap),
        .last_i (QW'(cfg.post_lim)),
        .wrap_o (post_wrap)
    );

    spidiv_sclk_gen u_gen (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .run_i  (en_i),
        .flip_i (post_wrap),
        .out_o  (clk_out)
    );

    assign sclk_o      = clk_out.level;
    assign half_tick_o = clk_out.edge_stb;
    assign full_tick_o = clk_out.close_stb;
endmodule

// File: rtl/spidiv_checker.sv
module spidiv_checker
    import spidiv_pkg::*;
(
    input logic              clk_i,
    input logic              rst_i,
    input logic              en_i,
    input logic [PRE_W-1:0]  pre_div_i,
    input logic [POST_W-1:0] post_div_i,
    input logic              sclk_o,
    input logic              half_tick_o,
    input logic              full_tick_o
);
    // Enabled edges since the last observed serial clock edge.
    logic [SPAN_W-1:0] gap_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || !en_i)
            gap_q <= '0;
        else if (half_tick_o)
            gap_q <= SPAN_W'(1);
        else if (gap_q != '1)
            gap_q <= gap_q + SPAN_W'(1);
    end

    p_idle_low_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> (!sclk_o && !half_tick_o && !full_tick_o));

    p_tick_marks_edge_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        half_tick_o |-> (sclk_o != $past(sclk_o)));

    p_half_window_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (half_tick_o && en_i) |-> (gap_q == half_span(pre_div_i, post_div_i)));

    p_close_on_fall_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        full_tick_o |-> (half_tick_o && !sclk_o));

    p_rise_needs_en_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(sclk_o) |-> $past(en_i));
endmodule

bind spidiv_top spidiv_checker u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .en_i        (en_i),
    .pre_div_i   (pre_div_i),
    .post_div_i  (post_div_i),
    .sclk_o      (sclk_o),
    .half_tick_o (half_tick_o),
    .full_tick_o (full_tick_o)
);

// File: tb/spidiv_top_tb_top.sv
`timescale 1ns/1ps
module spidiv_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic [7:0] pre = 8'd2;
    logic [7:0] post = 8'd0;
    logic       sclk, htick, ftick;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    spidiv_top dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .en_i        (en),
        .pre_div_i   (pre),
        .post_div_i  (post),
        .sclk_o      (sclk),
        .half_tick_o (htick),
        .full_tick_o (ftick)
    );

    // Expected half period from the requirements (R3, R5, R6).
    function automatic int exp_half(input int p, input int q);
        int pe;
        pe = p - (p % 2);
        if (pe < 2) pe = 2;
        return (q + 1) * pe / 2;
    endfunction

    // Behavioural reference, advanced on every rising edge.
    int m_n = 0;
    bit m_sclk = 0, m_half = 0, m_full = 0;

    always @(posedge clk) begin
        if (rst || !en) begin
            m_n = 0; m_sclk = 0; m_half = 0; m_full = 0;
        end else begin
            m_n++;
            if (m_n >= exp_half(pre, post)) begin
                m_n = 0;
                m_full = m_sclk;
                m_sclk = !m_sclk;
                m_half = 1;
            end else begin
                m_half = 0; m_full = 0;
            end
        end
    end

    // Per-clock comparison against the model (R3, R4, R8).
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (sclk !== m_sclk || htick !== m_half || ftick !== m_full) begin
                errors++;
                $display("FAIL R3 per-clock: got sclk=%0b half=%0b full=%0b exp %0b %0b %0b at %0t",
                         sclk, htick, ftick, m_sclk, m_half, m_full, $time);
            end
        end
    end

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Enable with the given setting, then time the first high and low phases.
    task automatic run_case(input string tag, input int p, input int q);
        int cnt;
        int h;
        h = exp_half(p, q);
        @(negedge clk);
        en = 0;
        @(negedge clk);
        pre = 8'(p); post = 8'(q);
        @(negedge clk);
        en = 1;
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (!sclk && cnt < 70000);
        check({tag, " first rise (R7)"}, cnt, h);
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (sclk && cnt < 70000);
        check({tag, " high phase (R4)"}, cnt, h);
        check({tag, " close strobe on fall (R8)"}, int'(ftick), 1);
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (!sclk && cnt < 70000);
        check({tag, " low phase (R3)"}, cnt, h);
    endtask

    initial begin
        int highs;
        int ticks;
        repeat (4) @(negedge clk);
        check("R1 reset sclk", int'(sclk), 0);
        check("R1 reset strobes", int'(htick | ftick), 0);
        rst = 0;
        @(negedge clk);
        check("R1 after release", int'(sclk | htick | ftick), 0);

        // R2: disabled with various settings
        highs = 0; ticks = 0;
        for (int k = 0; k < 4; k++) begin
            pre = 8'(k * 3); post = 8'(k);
            repeat (10) begin
                @(negedge clk);
                highs += int'(sclk);
                ticks += int'(htick | ftick);
            end
        end
        check("R2 idle level", highs, 0);
        check("R2 idle strobes", ticks, 0);

        run_case("R3 pre2 post0", 2, 0);
        run_case("R3 pre4 post2", 4, 2);
        run_case("R3 pre10 post5", 10, 5);
        run_case("R5 pre0", 0, 2);
        run_case("R5 pre1", 1, 2);
        run_case("R6 pre7", 7, 1);
        run_case("R6 pre255", 255, 0);

        // R9: drop enable mid-high, then re-enable
        run_case("R9 setup", 6, 3);
        repeat (3) @(negedge clk);
        en = 0;
        @(negedge clk);
        check("R9 parked low", int'(sclk), 0);
        repeat (5) @(negedge clk);
        run_case("R9 restart", 6, 3);

        run_case("R10 max ratio", 254, 255);

        @(negedge clk);
        en = 0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule